// File: doc/BRIEF.md
# Banked-Stack Control Register File

This block holds the control registers of a small 32-bit processor core. Software-visible control registers are selected by a 4-bit number. There is one registered read port and one write port. The block stores a packed status word, a second-level backup status byte, two saved program counters and two spare words. It also stores the two stack pointer copies, one for interrupt mode and one for user mode.

The active stack pointer is general register 15, and it lives inside this block. It is exposed through its own read/write port, so the rest of the register file can use it. Bit 7 of the current status byte is the stack mode bit, and it selects which stack copy is live in register 15. When a write to the status register changes that bit, the live value and the stored copy are exchanged on the same clock edge. A separate 8-bit status port gives the execution pipeline fast access to the status byte and the condition bit.

Top module: `ctlreg_file`

## Requirements
- R1: A synchronous active-high reset clears every stored register, the condition bit, the mode bit, `rd_data`, `stat_rd` and register 15.
- R2: Reading number 0 (status) returns the following, with all other bits zero:
  - the backup status byte AND 0xC1 in bits 15:8;
  - the current status byte AND 0xC0 in bits 7:0;
  - the condition bit in bit 0.
- R3: Writing number 0 loads bits 15:8 into the backup status byte and bits 7:0 into the current status byte. It also loads bit 0 into the condition bit.
- R4: A status write that takes the mode bit (current status bit 7) from 1 to 0 does two things on that edge: register 15 is saved into the user copy, and register 15 is reloaded from the interrupt copy. A change from 0 to 1 saves register 15 into the interrupt copy and reloads it from the user copy.
- R5: Number 2 (interrupt stack) reads and writes register 15 while the mode bit is 0, and the stored interrupt copy otherwise. Number 3 (user stack) reads and writes register 15 while the mode bit is 1, and the stored user copy otherwise.
- R6: Number 8 (second backup status) stores the low 8 bits of a write and reads back that byte AND 0xC1, zero-extended.
- R7: Number 1 (condition) reads the condition bit in bit 0. A write changes only the condition bit, taken from bit 0.
- R8: Numbers 6 and 7 (saved program counters) store all 32 written bits and read back with bit 0 forced to 0.
- R9: Numbers 4 and 5 are plain 32-bit storage. Numbers 9 to 15 read as 0 and ignore writes.
- R10: The status port reads `{current status[7:1], condition}`. A write sets the status byte and the condition bit, and never exchanges stack copies. A control write in the same cycle wins for the fields it writes.
- R11: `rd_data` and `stat_rd` show, one cycle after the request, the state before that edge. A write to the register being read in the same cycle therefore returns the old value.
- R12: `sp_rd` shows register 15. `sp_we` loads `sp_wd` into it unless a control write (aliased stack write or exchange) targets register 15 in the same cycle, in which case the control write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 4 | Control register number to read |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Control register write enable |
| wr_sel | input | 4 | Control register number to write |
| wr_data | input | 32 | Control register write data |
| stat_we | input | 1 | Status byte port write enable |
| stat_wd | input | 8 | Status byte port write data |
| stat_rd | output | 8 | Registered status byte port read data |
| sp_we | input | 1 | Register 15 write enable |
| sp_wd | input | 32 | Register 15 write data |
| sp_rd | output | 32 | Register 15 contents |

## Verification
Directed sequences do three things:
- They load distinct marker values into register 15 and both stack copies, then toggle the mode bit both ways, so a wrong exchange direction or a missing save is visible in `sp_rd` and in the aliased reads.
- They write odd values to the saved program counters and all-ones to the masked status fields, which separates masking faults from storage faults.
- They collide writes with reads of the same register, and control writes with status-port and register-15 writes, which shows the priority and old-value rules.

Several thousand cycles of random traffic over all sixteen numbers then mix random mode toggles with aliased stack writes, compared each cycle against a bench model.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int unsigned SELW = 4;
  localparam logic [SELW-1:0] SEL_STAT   = 4'd0;
  localparam logic [SELW-1:0] SEL_COND   = 4'd1;
  localparam logic [SELW-1:0] SEL_ISP    = 4'd2;
  localparam logic [SELW-1:0] SEL_USP    = 4'd3;
  localparam logic [SELW-1:0] SEL_SPARE0 = 4'd4;
  localparam logic [SELW-1:0] SEL_BPC0   = 4'd6;
  localparam logic [SELW-1:0] SEL_BSTAT2 = 4'd8;
  localparam int unsigned NSPARE = 2;
  localparam int unsigned NBPC   = 2;
  localparam int unsigned MODE_BIT = 7;
  localparam logic [7:0] BK_MASK  = 8'hC1;
  localparam logic [7:0] CUR_MASK = 8'hC0;
endpackage

// File: rtl/ctlreg_status.sv
module ctlreg_status (
  input  logic        clk,
  input  logic        rst,
  input  logic        stat_ctl_we,
  input  logic        cond_ctl_we,
  input  logic        bstat2_ctl_we,
  input  logic [15:0] wdata,
  input  logic        port_we,
  input  logic [7:0]  port_wd,
  output logic [7:0]  cur_q,
  output logic [7:0]  bk_q,
  output logic [7:0]  bstat2_q,
  output logic        cond_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      bk_q     <= '0;
      bstat2_q <= '0;
      cond_q   <= 1'b0;
    end else begin
      if (stat_ctl_we) begin
        bk_q   <= wdata[15:8];
        cur_q  <= wdata[7:0];
        cond_q <= wdata[0];
      end else if (port_we) begin
        cur_q  <= port_wd;
        cond_q <= port_wd[0];
      end
      if (cond_ctl_we)   cond_q   <= wdata[0];
      if (bstat2_ctl_we) bstat2_q <= wdata[7:0];
    end
  end

  p_stat_load_r3: assert property (@(posedge clk) disable iff (rst)
    stat_ctl_we |=> (bk_q == $past(wdata[15:8]) && cur_q == $past(wdata[7:0])
                     && cond_q == $past(wdata[0])));
  p_cond_only_r7: assert property (@(posedge clk) disable iff (rst)
    (cond_ctl_we && !port_we) |=> (cur_q == $past(cur_q) && bk_q == $past(bk_q)
                                   && cond_q == $past(wdata[0])));
endmodule

// File: rtl/ctlreg_sp_bank.sv
module ctlreg_sp_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode,
  input  logic         stat_ctl_we,
  input  logic         new_mode,
  input  logic         isp_we,
  input  logic         usp_we,
  input  logic [W-1:0] wdata,
  input  logic         gr_we,
  input  logic [W-1:0] gr_wd,
  output logic [W-1:0] gr_q,
  output logic [W-1:0] isp_view,
  output logic [W-1:0] usp_view
);
  logic [W-1:0] isp_q, usp_q;
  logic swap, gr_alias_we;

  assign swap        = stat_ctl_we && (new_mode != mode);
  assign gr_alias_we = (isp_we && !mode) || (usp_we && mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      gr_q  <= '0;
      isp_q <= '0;
      usp_q <= '0;
    end else begin
      if (swap)             gr_q <= mode ? isp_q : usp_q;
      else if (gr_alias_we) gr_q <= wdata;
      else if (gr_we)       gr_q <= gr_wd;

      if (swap && !mode)        isp_q <= gr_q;
      else if (isp_we && mode)  isp_q <= wdata;

      if (swap && mode)         usp_q <= gr_q;
      else if (usp_we && !mode) usp_q <= wdata;
    end
  end

  assign isp_view = mode ? isp_q : gr_q;
  assign usp_view = mode ? gr_q  : usp_q;

  p_swap_down_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_ctl_we && mode && !new_mode) |=> (usp_view == $past(gr_q) && gr_q == $past(isp_view)));
  p_swap_up_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_ctl_we && !mode && new_mode) |=> (isp_view == $past(gr_q) && gr_q == $past(usp_view)));
  p_alias_isp_r5: assert property (@(posedge clk) disable iff (rst)
    (isp_we && !mode) |=> gr_q == $past(wdata));
  p_alias_usp_r5: assert property (@(posedge clk) disable iff (rst)
    (usp_we && mode) |=> gr_q == $past(wdata));
  p_gr_port_r12: assert property (@(posedge clk) disable iff (rst)
    (gr_we && !stat_ctl_we && !isp_we && !usp_we) |=> gr_q == $past(gr_wd));
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
  import ctlreg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] rd_sel,
  output logic [W-1:0]    rd_data,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [W-1:0]    wr_data,
  input  logic            stat_we,
  input  logic [7:0]      stat_wd,
  output logic [7:0]      stat_rd,
  input  logic            sp_we,
  input  logic [W-1:0]    sp_wd,
  output logic [W-1:0]    sp_rd
);
  logic [7:0] cur_q, bk_q, bstat2_q;
  logic       cond_q;
  logic [W-1:0] gr_q, isp_view, usp_view;
  logic [W-1:0] spare_q [NSPARE];
  logic [W-1:0] bpc_q   [NBPC];
  logic [W-1:0] rd_next;
  logic [7:0]   stat_pack;

  ctlreg_status u_status (
    .clk(clk), .rst(rst),
    .stat_ctl_we(wr_en && wr_sel == SEL_STAT),
    .cond_ctl_we(wr_en && wr_sel == SEL_COND),
    .bstat2_ctl_we(wr_en && wr_sel == SEL_BSTAT2),
    .wdata(wr_data[15:0]),
    .port_we(stat_we), .port_wd(stat_wd),
    .cur_q(cur_q), .bk_q(bk_q), .bstat2_q(bstat2_q), .cond_q(cond_q)
  );

  ctlreg_sp_bank #(.W(W)) u_sp (
    .clk(clk), .rst(rst),
    .mode(cur_q[MODE_BIT]),
    .stat_ctl_we(wr_en && wr_sel == SEL_STAT),
    .new_mode(wr_data[MODE_BIT]),
    .isp_we(wr_en && wr_sel == SEL_ISP),
    .usp_we(wr_en && wr_sel == SEL_USP),
    .wdata(wr_data),
    .gr_we(sp_we), .gr_wd(sp_wd),
    .gr_q(gr_q), .isp_view(isp_view), .usp_view(usp_view)
  );

  for (genvar g = 0; g < NSPARE; g++) begin : g_spare
    always_ff @(posedge clk) begin
      if (rst) spare_q[g] <= '0;
      else if (wr_en && wr_sel == SEL_SPARE0 + SELW'(g)) spare_q[g] <= wr_data;
    end
  end

  for (genvar g = 0; g < NBPC; g++) begin : g_bpc
    always_ff @(posedge clk) begin
      if (rst) bpc_q[g] <= '0;
      else if (wr_en && wr_sel == SEL_BPC0 + SELW'(g)) bpc_q[g] <= wr_data;
    end
  end

  assign stat_pack = (cur_q & CUR_MASK) | {7'b0, cond_q};

  always_comb begin
    rd_next = '0;
    case (rd_sel)
      SEL_STAT:              rd_next = W'({bk_q & BK_MASK, stat_pack});
      SEL_COND:              rd_next = W'(cond_q);
      SEL_ISP:               rd_next = isp_view;
      SEL_USP:               rd_next = usp_view;
      SEL_SPARE0:            rd_next = spare_q[0];
      SEL_SPARE0 + 4'd1:     rd_next = spare_q[1];
      SEL_BPC0:              rd_next = {bpc_q[0][W-1:1], 1'b0};
      SEL_BPC0 + 4'd1:       rd_next = {bpc_q[1][W-1:1], 1'b0};
      SEL_BSTAT2:            rd_next = W'(bstat2_q & BK_MASK);
      default:               rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      stat_rd <= '0;
    end else begin
      rd_data <= rd_next;
      stat_rd <= {cur_q[7:1], cond_q};
    end
  end

  assign sp_rd = gr_q;

  p_stat_pack_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_STAT) |=> (rd_data[W-1:16] == '0 && rd_data[13:9] == '0 && rd_data[5:1] == '0));
  p_bpc_lsb_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_BPC0 || rd_sel == SEL_BPC0 + 4'd1) |=> rd_data[0] == 1'b0);
  p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_sel > SEL_BSTAT2) |=> rd_data == '0);
  p_bstat2_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_BSTAT2) |=> (rd_data[W-1:8] == '0 && rd_data[5:1] == '0));
  p_port_noswap_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_we && !wr_en && !sp_we) |=> $stable(sp_rd));
endmodule

// File: tb/ctlreg_file_test.sv
`timescale 1ns/1ps
module ctlreg_file_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] rd_sel = '0, wr_sel = '0;
  logic wr_en = 1'b0, stat_we = 1'b0, sp_we = 1'b0;
  logic [31:0] wr_data = '0, sp_wd = '0;
  logic [7:0] stat_wd = '0;
  logic [31:0] rd_data, sp_rd;
  logic [7:0] stat_rd;

  int checks = 0, fails = 0;

  logic [7:0]  m_cur, m_bk, m_bb;
  logic        m_cond;
  logic [31:0] m_gr, m_isp, m_usp, m_sp0, m_sp1, m_bpc, m_bbpc;

  always #2 clk = ~clk;

  ctlreg_file uut (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stat_we(stat_we), .stat_wd(stat_wd), .stat_rd(stat_rd),
    .sp_we(sp_we), .sp_wd(sp_wd), .sp_rd(sp_rd)
  );

  function automatic string tag_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2/R3";
      4'd1: return "R7";
      4'd2, 4'd3: return "R5";
      4'd4, 4'd5: return "R9";
      4'd6, 4'd7: return "R8";
      4'd8: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] s);
    case (s)
      4'd0: return {16'h0, m_bk & 8'hC1, (m_cur & 8'hC0) | {7'b0, m_cond}};
      4'd1: return {31'b0, m_cond};
      4'd2: return m_cur[7] ? m_isp : m_gr;
      4'd3: return m_cur[7] ? m_gr : m_usp;
      4'd4: return m_sp0;
      4'd5: return m_sp1;
      4'd6: return {m_bpc[31:1], 1'b0};
      4'd7: return {m_bbpc[31:1], 1'b0};
      4'd8: return {24'h0, m_bb & 8'hC1};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cur = '0; m_bk = '0; m_bb = '0; m_cond = 1'b0;
    m_gr = '0; m_isp = '0; m_usp = '0; m_sp0 = '0; m_sp1 = '0; m_bpc = '0; m_bbpc = '0;
  endtask

  // Drive at the falling edge, compute expectations, check at the next falling edge.
  task automatic step(input logic [3:0] rs, input logic we, input logic [3:0] ws,
                      input logic [31:0] wd, input logic swe, input logic [7:0] swd,
                      input logic gwe, input logic [31:0] gwd);
    logic [31:0] exp_rd, o_gr;
    logic [7:0]  exp_sw;
    logic        o_mode;
    rd_sel = rs; wr_en = we; wr_sel = ws; wr_data = wd;
    stat_we = swe; stat_wd = swd; sp_we = gwe; sp_wd = gwd;
    exp_rd = model_read(rs);
    exp_sw = {m_cur[7:1], m_cond};
    o_gr = m_gr; o_mode = m_cur[7];
    if (gwe) m_gr = gwd;
    if (swe) begin m_cur = swd; m_cond = swd[0]; end
    if (we) begin
      case (ws)
        4'd0: begin
          m_bk = wd[15:8]; m_cur = wd[7:0]; m_cond = wd[0];
          if (wd[7] != o_mode) begin
            if (o_mode) begin m_usp = o_gr; m_gr = m_isp; end
            else        begin m_isp = o_gr; m_gr = m_usp; end
          end
        end
        4'd1: m_cond = wd[0];
        4'd2: if (!o_mode) m_gr = wd; else m_isp = wd;
        4'd3: if (o_mode) m_gr = wd; else m_usp = wd;
        4'd4: m_sp0 = wd;
        4'd5: m_sp1 = wd;
        4'd6: m_bpc = wd;
        4'd7: m_bbpc = wd;
        4'd8: m_bb = wd[7:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check32({tag_of(rs), " R11 read"}, rd_data, exp_rd);
    check32("R10 status port", {24'h0, stat_rd}, {24'h0, exp_sw});
    check32("R4/R5/R12 reg15", sp_rd, m_gr);
    wr_en = 1'b0; stat_we = 1'b0; sp_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check32("R1 rd_data", rd_data, 32'h0);
    check32("R1 stat_rd", {24'h0, stat_rd}, 32'h0);
    check32("R1 sp_rd", sp_rd, 32'h0);

    // R12 then R5/R4: markers into reg15 and user copy, toggle mode both ways
    step(4'd2, 1'b0, 4'd0, 32'h0, 1'b0, 8'h0, 1'b1, 32'h1111_0000);
    step(4'd3, 1'b1, 4'd3, 32'h2222_0000, 1'b0, 8'h0, 1'b0, 32'h0);
    step(4'd3, 1'b1, 4'd0, 32'h0000_FF80, 1'b0, 8'h0, 1'b0, 32'h0); // R4 0->1
    step(4'd2, 1'b0, 4'd0, 32'h0, 1'b0, 8'h0, 1'b0, 32'h0);
    step(4'd0, 1'b1, 4'd2, 32'h3333_0000, 1'b0, 8'h0, 1'b1, 32'h4444_0000); // R5 stored copy, R12 port
    step(4'd0, 1'b1, 4'd0, 32'h0000_0001, 1'b0, 8'h0, 1'b1, 32'h5555_0000); // R4 1->0 wins over R12
    step(4'd3, 1'b0, 4'd0, 32'h0, 1'b0, 8'h0, 1'b0, 32'h0);
    // R7 condition only
    step(4'd1, 1'b1, 4'd1, 32'hFFFF_FFFE, 1'b0, 8'h0, 1'b0, 32'h0);
    step(4'd0, 1'b0, 4'd0, 32'h0, 1'b0, 8'h0, 1'b0, 32'h0);
    // R8 odd values
    step(4'd6, 1'b1, 4'd6, 32'hDEAD_BEEF, 1'b0, 8'h0, 1'b0, 32'h0);
    step(4'd6, 1'b1, 4'd7, 32'h0000_0003, 1'b0, 8'h0, 1'b0, 32'h0);
    step(4'd7, 1'b0, 4'd0, 32'h0, 1'b0, 8'h0, 1'b0, 32'h0);
    // R6 and R9
    step(4'd8, 1'b1, 4'd8, 32'hFFFF_FFFF, 1'b0, 8'h0, 1'b0, 32'h0);
    step(4'd8, 1'b1, 4'd12, 32'hFFFF_FFFF, 1'b0, 8'h0, 1'b0, 32'h0);
    step(4'd12, 1'b0, 4'd0, 32'h0, 1'b0, 8'h0, 1'b0, 32'h0);
    // R11 same-cycle read and write of a spare
    step(4'd4, 1'b1, 4'd4, 32'hA5A5_5A5A, 1'b0, 8'h0, 1'b0, 32'h0);
    step(4'd4, 1'b1, 4'd4, 32'h0F0F_F0F0, 1'b0, 8'h0, 1'b0, 32'h0);
    step(4'd4, 1'b0, 4'd0, 32'h0, 1'b0, 8'h0, 1'b0, 32'h0);
    // R10 status port: sets mode bit without exchange, then collision with cond write
    step(4'd0, 1'b0, 4'd0, 32'h0, 1'b1, 8'hFF, 1'b0, 32'h0);
    step(4'd2, 1'b1, 4'd1, 32'h0, 1'b1, 8'h41, 1'b0, 32'h0);
    step(4'd0, 1'b0, 4'd0, 32'h0, 1'b0, 8'h0, 1'b0, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] rs, ws;
      logic [31:0] wd;
      rs = 4'($urandom_range(0, 15));
      ws = ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
      wd = $urandom;
      step(rs, ($urandom_range(0, 1) == 1), ws, wd,
           ($urandom_range(0, 5) == 0), 8'($urandom),
           ($urandom_range(0, 2) == 0), $urandom);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule